// File: doc/BRIEF.md
# Indirect Register Video Memory Engine

This block is the host-facing register file of a video controller. A host reaches it through two byte-wide ports that share one data bus. A write on the index port picks an internal register. Reads and writes on the data port then act on that register. A read of the index port returns a ready flag, and the host polls that flag before each data-port access. Behind the registers, the block drives a 64 KB local video RAM through a synchronous single-port interface with one cycle of read latency.

Memory is never addressed directly. A 16-bit update address is loaded through two registers. The memory data register then stores or returns one byte at that address, and the address steps forward by one after each access. A block engine fills or copies up to 256 bytes per command. The byte count is written to a trigger register, and that write starts the command. The fill or copy choice and the copy source address are taken from other registers. One display mode register is only stored; its top bit is brought out as a bitmap-enable level for the display logic. The memory byte at the current update address is prefetched into a read latch, so a data-port read of the memory data register is answered at once.

Top module: `vmem_regport`

## Requirements
- R1: A read of the index port (host_sel=0) returns the ready flag in bit 7 and zeros in bits 6..0. A write of the index port selects the register used by later data-port accesses (host_sel=1).
- R2: The update address is register 18 (high byte) and register 19 (low byte). Both read back as written. After either one is written, a read of register 31 returns the memory byte at the new address.
- R3: A write of register 31 stores the byte at the update address and then increments that address by one. The increment wraps from 0xFFFF to 0x0000.
- R4: A read of register 31 returns the byte at the update address and then increments that address by one.
- R5: With bit 7 of register 24 at 0, a write of count N to register 30 writes the last value written to register 31 into N bytes, starting at the update address. Afterwards the update address equals the start address plus N, and the byte after the range is unchanged.
- R6: With bit 7 of register 24 at 1, a write of count N to register 30 copies N bytes from the source address to the update address. The source address is register 32 (high byte) and register 33 (low byte). Afterwards both addresses have advanced by N.
- R7: A count of 0 written to register 30 moves 256 bytes.
- R8: The ready flag reads 0 while a block command, a single-byte access or a prefetch is pending. It reads 1 again once the work is done.
- R9: A data-port write while the flag reads 0 changes no register and no memory byte. It sets err_flag, which stays at 1 until reset.
- R10: Register 25 reads back the whole byte last written to it. Output bitmap_on follows its bit 7.
- R11: After reset, err_flag is 0, bitmap_on is 0, the update and source addresses are 0, and the ready flag rises on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_sel | input | 1 | Port select: 0 for the index port, 1 for the data port |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_rd | input | 1 | Host read strobe, one cycle per read |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Host read data, combinational from port select and register index |
| err_flag | output | 1 | Sticky flag for a data write refused while busy |
| bitmap_on | output | 1 | Bit 7 of display mode register 25 |
| mem_addr | output | ADDR_W | Video RAM address |
| mem_re | output | 1 | Video RAM read enable; data is returned on the next cycle |
| mem_we | output | 1 | Video RAM write enable |
| mem_wdata | output | DATA_W | Video RAM write data |
| mem_rdata | input | DATA_W | Video RAM read data |

## Verification
Two functions can fall in the same cycle: a block fill stepping through memory, and a host data-port write. The bench provokes this by writing the count register and then sending a data write to that same register at once, while the fill still has several bytes to go. The collision is judged at the ports. The ready flag must read 0 mid-fill and err_flag must rise. The count readback, the final update address and the byte after the filled range must all match a fill that was never restarted.

// File: rtl/vmem_pkg.sv
package vmem_pkg;

   // Register numbers are decoded by host software, so they are kept fixed.
   localparam int unsigned RG_UPD_HI   = 18;
   localparam int unsigned RG_UPD_LO   = 19;
   localparam int unsigned RG_BLK_MODE = 24;
   localparam int unsigned RG_DISP     = 25;
   localparam int unsigned RG_BLK_CNT  = 30;
   localparam int unsigned RG_MEM_DATA = 31;
   localparam int unsigned RG_SRC_HI   = 32;
   localparam int unsigned RG_SRC_LO   = 33;

   typedef enum logic [2:0] {
      ST_IDLE,   // ready for the host
      ST_PREF,   // issue prefetch read at update address
      ST_PCAP,   // capture prefetched byte
      ST_SWR,    // single byte store
      ST_FILL,   // block fill, one byte per cycle
      ST_CRD,    // block copy, read source
      ST_CWR     // block copy, write destination
   } eng_state_t;

endpackage

// File: rtl/vmem_hostif.sv
module vmem_hostif
   import vmem_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_sel,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic              eng_ready,
   input  logic [ADDR_W-1:0] upd_addr,
   input  logic [ADDR_W-1:0] src_addr,
   input  logic [DATA_W-1:0] rd_latch,
   output logic [DATA_W-1:0] cur_idx,
   output logic              data_wr_ok,
   output logic              mem_rd_ok,
   output logic              copy_sel,
   output logic              err_flag,
   output logic              bitmap_on,
   output logic [DATA_W-1:0] host_rdata
);

   localparam logic [DATA_W-1:0] IX_UPD_HI = DATA_W'(RG_UPD_HI);
   localparam logic [DATA_W-1:0] IX_UPD_LO = DATA_W'(RG_UPD_LO);
   localparam logic [DATA_W-1:0] IX_BLK    = DATA_W'(RG_BLK_MODE);
   localparam logic [DATA_W-1:0] IX_DISP   = DATA_W'(RG_DISP);
   localparam logic [DATA_W-1:0] IX_CNT    = DATA_W'(RG_BLK_CNT);
   localparam logic [DATA_W-1:0] IX_MEM    = DATA_W'(RG_MEM_DATA);
   localparam logic [DATA_W-1:0] IX_SRC_HI = DATA_W'(RG_SRC_HI);
   localparam logic [DATA_W-1:0] IX_SRC_LO = DATA_W'(RG_SRC_LO);

   logic [DATA_W-1:0] idx_q;
   logic [DATA_W-1:0] disp_q;
   logic [DATA_W-1:0] cnt_q;
   logic              copy_q;
   logic              err_q;

   // data-port accesses are taken only while the engine is idle (R8, R9)
   assign data_wr_ok = host_wr && host_sel && eng_ready;
   assign mem_rd_ok  = host_rd && !host_wr && host_sel && eng_ready && (idx_q == IX_MEM);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q  <= '0;
         disp_q <= '0;
         cnt_q  <= '0;
         copy_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         if (host_wr && !host_sel)
            idx_q <= host_wdata;
         if (host_wr && host_sel && !eng_ready)
            err_q <= 1'b1;                       // R9 sticky
         if (data_wr_ok) begin
            case (idx_q)
               IX_BLK:  copy_q <= host_wdata[DATA_W-1];
               IX_DISP: disp_q <= host_wdata;   // R10 whole byte kept
               IX_CNT:  cnt_q  <= host_wdata;
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      host_rdata = '0;
      if (!host_sel) begin
         host_rdata[DATA_W-1] = eng_ready;      // R1
      end else begin
         case (idx_q)
            IX_UPD_HI: host_rdata = upd_addr[ADDR_W-1:DATA_W];
            IX_UPD_LO: host_rdata = upd_addr[DATA_W-1:0];
            IX_BLK:    host_rdata = {copy_q, {(DATA_W-1){1'b0}}};
            IX_DISP:   host_rdata = disp_q;
            IX_CNT:    host_rdata = cnt_q;
            IX_MEM:    host_rdata = rd_latch;
            IX_SRC_HI: host_rdata = src_addr[ADDR_W-1:DATA_W];
            IX_SRC_LO: host_rdata = src_addr[DATA_W-1:0];
            default:   host_rdata = '0;
         endcase
      end
   end

   assign cur_idx   = idx_q;
   assign copy_sel  = copy_q;
   assign err_flag  = err_q;
   assign bitmap_on = disp_q[DATA_W-1];

endmodule

// File: rtl/vmem_engine.sv
module vmem_engine
   import vmem_pkg::*;
#(
   parameter int unsigned DATA_W       = 8,
   parameter int unsigned ADDR_W       = 16,
   parameter bit          ZERO_IS_FULL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_wr,
   input  logic              cmd_rd,
   input  logic [DATA_W-1:0] cur_idx,
   input  logic [DATA_W-1:0] wdata,
   input  logic              copy_sel,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              ready,
   output logic [ADDR_W-1:0] upd_addr,
   output logic [ADDR_W-1:0] src_addr,
   output logic [DATA_W-1:0] rd_latch,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_re,
   output logic              mem_we,
   output logic [DATA_W-1:0] mem_wdata
);

   localparam int unsigned CNT_W = DATA_W + 1;
   localparam logic [DATA_W-1:0] IX_UPD_HI = DATA_W'(RG_UPD_HI);
   localparam logic [DATA_W-1:0] IX_UPD_LO = DATA_W'(RG_UPD_LO);
   localparam logic [DATA_W-1:0] IX_CNT    = DATA_W'(RG_BLK_CNT);
   localparam logic [DATA_W-1:0] IX_MEM    = DATA_W'(RG_MEM_DATA);
   localparam logic [DATA_W-1:0] IX_SRC_HI = DATA_W'(RG_SRC_HI);
   localparam logic [DATA_W-1:0] IX_SRC_LO = DATA_W'(RG_SRC_LO);

   eng_state_t        st_q;
   logic [ADDR_W-1:0] upd_q;
   logic [ADDR_W-1:0] src_q;
   logic [DATA_W-1:0] latch_q;
   logic [DATA_W-1:0] fill_q;
   logic [CNT_W-1:0]  rem_q;
   logic [CNT_W-1:0]  cnt_load;
   logic              blk_go;
   logic              last_byte;

   // count decode variant (R7)
   generate
      if (ZERO_IS_FULL) begin : g_zero_full
         assign cnt_load = (wdata == '0) ? {1'b1, {DATA_W{1'b0}}} : {1'b0, wdata};
         assign blk_go   = 1'b1;
      end else begin : g_zero_skip
         assign cnt_load = {1'b0, wdata};
         assign blk_go   = (wdata != '0);
      end
   endgenerate

   assign last_byte = (rem_q == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_PREF;
         upd_q   <= '0;
         src_q   <= '0;
         latch_q <= '0;
         fill_q  <= '0;
         rem_q   <= '0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (cmd_wr) begin
                  case (cur_idx)
                     IX_UPD_HI: begin
                        upd_q[ADDR_W-1:DATA_W] <= wdata;   // R2
                        st_q <= ST_PREF;
                     end
                     IX_UPD_LO: begin
                        upd_q[DATA_W-1:0] <= wdata;
                        st_q <= ST_PREF;
                     end
                     IX_MEM: begin
                        fill_q <= wdata;                   // R3, fill source for R5
                        st_q   <= ST_SWR;
                     end
                     IX_CNT: begin
                        if (blk_go) begin
                           rem_q <= cnt_load;
                           st_q  <= copy_sel ? ST_CRD : ST_FILL;
                        end
                     end
                     IX_SRC_HI: src_q[ADDR_W-1:DATA_W] <= wdata;
                     IX_SRC_LO: src_q[DATA_W-1:0]      <= wdata;
                     default: ;
                  endcase
               end else if (cmd_rd) begin
                  upd_q <= upd_q + 1'b1;                   // R4
                  st_q  <= ST_PREF;
               end
            end
            ST_PREF: st_q <= ST_PCAP;
            ST_PCAP: begin
               latch_q <= mem_rdata;
               st_q    <= ST_IDLE;
            end
            ST_SWR: begin
               upd_q <= upd_q + 1'b1;
               st_q  <= ST_PREF;
            end
            ST_FILL: begin
               upd_q <= upd_q + 1'b1;
               rem_q <= rem_q - 1'b1;
               st_q  <= last_byte ? ST_PREF : ST_FILL;
            end
            ST_CRD: st_q <= ST_CWR;
            ST_CWR: begin
               upd_q <= upd_q + 1'b1;
               src_q <= src_q + 1'b1;                      // R6
               rem_q <= rem_q - 1'b1;
               st_q  <= last_byte ? ST_PREF : ST_CRD;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign ready     = (st_q == ST_IDLE);
   assign mem_re    = (st_q == ST_PREF) || (st_q == ST_CRD);
   assign mem_we    = (st_q == ST_SWR) || (st_q == ST_FILL) || (st_q == ST_CWR);
   assign mem_addr  = (st_q == ST_CRD) ? src_q : upd_q;
   assign mem_wdata = (st_q == ST_CWR) ? mem_rdata : fill_q;
   assign upd_addr  = upd_q;
   assign src_addr  = src_q;
   assign rd_latch  = latch_q;

endmodule

// File: rtl/vmem_regport.sv
module vmem_regport
   import vmem_pkg::*;
#(
   parameter int unsigned DATA_W       = 8,
   parameter int unsigned ADDR_W       = 16,
   parameter bit          ZERO_IS_FULL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_sel,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   output logic              err_flag,
   output logic              bitmap_on,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_re,
   output logic              mem_we,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata
);

   generate
      if (ADDR_W != 2 * DATA_W) begin : g_bad_addr_w
         $error("vmem_regport: ADDR_W must be twice DATA_W");
      end
      if (DATA_W < 8) begin : g_bad_data_w
         $error("vmem_regport: DATA_W must be at least 8");
      end
   endgenerate

   logic              eng_ready;
   logic [ADDR_W-1:0] upd_addr;
   logic [ADDR_W-1:0] src_addr;
   logic [DATA_W-1:0] rd_latch;
   logic [DATA_W-1:0] cur_idx;
   logic              data_wr_ok;
   logic              mem_rd_ok;
   logic              copy_sel;

   vmem_hostif #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W)
   ) u_hostif (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_sel   (host_sel),
      .host_wr    (host_wr),
      .host_rd    (host_rd),
      .host_wdata (host_wdata),
      .eng_ready  (eng_ready),
      .upd_addr   (upd_addr),
      .src_addr   (src_addr),
      .rd_latch   (rd_latch),
      .cur_idx    (cur_idx),
      .data_wr_ok (data_wr_ok),
      .mem_rd_ok  (mem_rd_ok),
      .copy_sel   (copy_sel),
      .err_flag   (err_flag),
      .bitmap_on  (bitmap_on),
      .host_rdata (host_rdata)
   );

   vmem_engine #(
      .DATA_W       (DATA_W),
      .ADDR_W       (ADDR_W),
      .ZERO_IS_FULL (ZERO_IS_FULL)
   ) u_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_wr    (data_wr_ok),
      .cmd_rd    (mem_rd_ok),
      .cur_idx   (cur_idx),
      .wdata     (host_wdata),
      .copy_sel  (copy_sel),
      .mem_rdata (mem_rdata),
      .ready     (eng_ready),
      .upd_addr  (upd_addr),
      .src_addr  (src_addr),
      .rd_latch  (rd_latch),
      .mem_addr  (mem_addr),
      .mem_re    (mem_re),
      .mem_we    (mem_we),
      .mem_wdata (mem_wdata)
   );

endmodule

// File: rtl/vmem_regport_chk.sv
module vmem_regport_chk
   import vmem_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_sel,
   input logic              host_wr,
   input logic [DATA_W-1:0] host_rdata,
   input logic              err_flag,
   input logic              mem_we,
   input logic              mem_re,
   input logic              ready,
   input logic [ADDR_W-1:0] upd_addr,
   input logic [DATA_W-1:0] cur_idx
);

   p_busy_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!host_sel && (mem_we || mem_re)) |-> (host_rdata == '0));

   p_busy_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we || mem_re) |-> !ready);

   p_err_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag |=> err_flag);

   p_err_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && host_sel && !ready) |=> err_flag);

   p_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && host_wr && host_sel && (cur_idx == DATA_W'(RG_MEM_DATA))) |=> mem_we);

   p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> (upd_addr == ADDR_W'($past(upd_addr) + 1'b1)));

endmodule

bind vmem_regport vmem_regport_chk #(
   .DATA_W (DATA_W),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .host_sel   (host_sel),
   .host_wr    (host_wr),
   .host_rdata (host_rdata),
   .err_flag   (err_flag),
   .mem_we     (mem_we),
   .mem_re     (mem_re),
   .ready      (eng_ready),
   .upd_addr   (upd_addr),
   .cur_idx    (cur_idx)
);

// File: tb/vmem_regport_bench.sv
`timescale 1ns/1ps
module vmem_regport_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_sel = 1'b0;
   logic        host_wr = 1'b0;
   logic        host_rd = 1'b0;
   logic [7:0]  host_wdata = 8'h00;
   logic [7:0]  host_rdata;
   logic        err_flag;
   logic        bitmap_on;
   logic [15:0] mem_addr;
   logic        mem_re;
   logic        mem_we;
   logic [7:0]  mem_wdata;
   logic [7:0]  mem_rdata = 8'h00;

   int checks = 0;
   int fails  = 0;

   logic [7:0] exp_val_q[$];
   string      exp_req_q[$];

   always #2.5 clk = ~clk;

   vmem_regport u_vmem_regport (
      .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
      .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .err_flag(err_flag), .bitmap_on(bitmap_on), .mem_addr(mem_addr),
      .mem_re(mem_re), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   // video RAM model: 4 KB aliased window, one cycle read latency
   logic [7:0] vram [0:4095];
   initial for (int i = 0; i < 4096; i++) vram[i] = 8'h00;
   always @(posedge clk) begin
      if (mem_we) vram[mem_addr[11:0]] <= mem_wdata;
      if (mem_re) mem_rdata <= vram[mem_addr[11:0]];
   end

   task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // scoreboard monitor: pops an expected item for each host read
   always @(negedge clk) begin
      #1;
      if (host_rd) begin
         if (exp_val_q.size() == 0) begin
            checks++; fails++;
            $display("FAIL scoreboard actual=%h expected=none", host_rdata);
         end else begin
            check(host_rdata, exp_val_q.pop_front(), exp_req_q.pop_front());
         end
      end
   end

   task automatic port_wr(input logic p, input logic [7:0] v);
      @(negedge clk);
      host_sel = p; host_wr = 1'b1; host_wdata = v;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic wait_rdy;
      host_sel = 1'b0;
      #1;
      while (host_rdata[7] !== 1'b1) begin
         @(negedge clk);
         #1;
      end
   endtask

   task automatic set_reg(input logic [7:0] r, input logic [7:0] v);
      wait_rdy();
      port_wr(1'b0, r);
      port_wr(1'b1, v);
   endtask

   task automatic get_reg(input logic [7:0] r, input logic [7:0] exp, input string req);
      wait_rdy();
      port_wr(1'b0, r);
      @(negedge clk);
      host_sel = 1'b1; host_rd = 1'b1;
      exp_val_q.push_back(exp);
      exp_req_q.push_back(req);
      @(negedge clk);
      host_rd = 1'b0;
   endtask

   task automatic set_addr(input logic [15:0] a);
      set_reg(8'd18, a[15:8]);
      set_reg(8'd19, a[7:0]);
   endtask

   task automatic finish_run;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; fails++;
      $display("FAIL R8 watchdog actual=busy expected=ready");
      finish_run();
   end

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check({7'b0, err_flag}, 8'h00, "R11");
      check({7'b0, bitmap_on}, 8'h00, "R11");
      wait_rdy();
      check(host_rdata, 8'h80, "R1");
      get_reg(8'd18, 8'h00, "R11");
      get_reg(8'd19, 8'h00, "R11");
      get_reg(8'd32, 8'h00, "R11");
      get_reg(8'd33, 8'h00, "R11");

      // single writes through register 31
      set_addr(16'h0100);
      get_reg(8'd18, 8'h01, "R2");
      set_reg(8'd31, 8'h11);
      set_reg(8'd31, 8'h22);
      set_reg(8'd31, 8'h33);
      get_reg(8'd19, 8'h03, "R3");

      // single reads
      set_addr(16'h0100);
      get_reg(8'd31, 8'h11, "R2");
      get_reg(8'd31, 8'h22, "R4");
      get_reg(8'd31, 8'h33, "R4");
      get_reg(8'd19, 8'h03, "R4");

      // fill of 5 bytes
      set_addr(16'h01FF);
      set_reg(8'd31, 8'hA5);
      set_reg(8'd24, 8'h00);
      set_reg(8'd30, 8'd5);
      get_reg(8'd18, 8'h02, "R5");
      get_reg(8'd19, 8'h05, "R5");
      set_addr(16'h01FF);
      for (int i = 0; i < 6; i++) get_reg(8'd31, 8'hA5, "R5");
      get_reg(8'd31, 8'h00, "R5");

      // copy of 3 bytes
      set_reg(8'd24, 8'h80);
      get_reg(8'd24, 8'h80, "R6");
      set_reg(8'd32, 8'h01);
      set_reg(8'd33, 8'h00);
      set_addr(16'h0300);
      set_reg(8'd30, 8'd3);
      get_reg(8'd32, 8'h01, "R6");
      get_reg(8'd33, 8'h03, "R6");
      get_reg(8'd18, 8'h03, "R6");
      get_reg(8'd19, 8'h03, "R6");
      set_addr(16'h0300);
      get_reg(8'd31, 8'h11, "R6");
      get_reg(8'd31, 8'h22, "R6");
      get_reg(8'd31, 8'h33, "R6");
      get_reg(8'd31, 8'h00, "R6");

      // count 0 moves 256 bytes
      set_reg(8'd24, 8'h00);
      set_addr(16'h0400);
      set_reg(8'd31, 8'h5A);
      set_reg(8'd30, 8'h00);
      get_reg(8'd18, 8'h05, "R7");
      get_reg(8'd19, 8'h01, "R7");
      set_addr(16'h0500);
      get_reg(8'd31, 8'h5A, "R7");
      get_reg(8'd31, 8'h00, "R7");

      // data write colliding with a running fill
      set_addr(16'h0600);
      set_reg(8'd31, 8'hC3);
      check({7'b0, err_flag}, 8'h00, "R9");
      set_reg(8'd30, 8'd10);
      host_sel = 1'b0;
      #1;
      check(host_rdata, 8'h00, "R8");
      port_wr(1'b1, 8'h77);
      #1;
      check({7'b0, err_flag}, 8'h01, "R9");
      wait_rdy();
      check(host_rdata, 8'h80, "R8");
      check({7'b0, err_flag}, 8'h01, "R9");
      get_reg(8'd30, 8'd10, "R9");
      get_reg(8'd18, 8'h06, "R9");
      get_reg(8'd19, 8'h0B, "R9");
      set_addr(16'h060A);
      get_reg(8'd31, 8'hC3, "R5");
      get_reg(8'd31, 8'h00, "R9");

      // update address wrap
      set_addr(16'hFFFF);
      set_reg(8'd31, 8'h3C);
      get_reg(8'd18, 8'h00, "R3");
      get_reg(8'd19, 8'h00, "R3");
      check(vram[12'hFFF], 8'h3C, "R3");

      // display mode byte kept whole
      set_reg(8'd25, 8'h47);
      check({7'b0, bitmap_on}, 8'h00, "R10");
      get_reg(8'd25, 8'h47, "R10");
      set_reg(8'd25, 8'hC7);
      check({7'b0, bitmap_on}, 8'h01, "R10");
      get_reg(8'd25, 8'hC7, "R10");

      // index selects the register: same data port, different registers
      set_reg(8'd33, 8'h9E);
      get_reg(8'd33, 8'h9E, "R1");
      get_reg(8'd32, 8'h01, "R1");

      repeat (4) @(negedge clk);
      if (exp_val_q.size() != 0) begin
         checks++; fails++;
         $display("FAIL scoreboard actual=%0d expected=0 pending", exp_val_q.size());
      end
      finish_run();
   end

endmodule